// File: doc/BRIEF.md
# Banked Internal Data RAM

This block is the 128-byte on-chip data memory of a small 8-bit core. The same storage can be reached in five ways. A register port takes a 3-bit register number and uses two bank-select bits to map it into one of four 8-byte banks. A direct port takes a full 7-bit byte address. An indirect port takes its address from working register 0 or 1 of the active bank. A bit port reads, sets or clears single bits in a 16-byte bit region. A stack port keeps an 8-bit stack pointer and provides push and pop strobes.

All read paths are combinational, so a read sees the stored contents at the time of the read. All writes take effect at the rising clock edge, and at most one byte is written per cycle, chosen by a fixed priority. An indirect or stack access whose 8-bit address is above 7FH is flagged on an output. That access writes nothing and returns zero, so it never folds back into the 128 bytes. The special function register space, the ALU and instruction decoding belong to other blocks of the core.

Top module: `iram_bank_file`

## Requirements
- R1: After reset every byte holds 00H and the stack pointer `sp_o` holds 07H.
- R2: A register-port access to register number i (0..7) with bank select b (0..3) reaches byte address 8*b + i. Bank 0 covers 00H–07H, bank 1 covers 08H–0FH, bank 2 covers 10H–17H and bank 3 covers 18H–1FH.
- R3: The direct port reaches all 128 bytes by a 7-bit address. Direct addresses 00H–07H always reach bank 0, whatever the bank select.
- R4: Bit address n (7 bits) selects bit n[2:0] of byte 20H + n[6:3]. `bit_rd_o` returns that bit. `bit_set_i` writes it to 1 and `bit_clr_i` writes it to 0, leaving the other seven bits of the byte unchanged. When both strobes are high, set wins.
- R5: The indirect port uses the byte held in register 0 (`ind_sel_i`=0) or register 1 (`ind_sel_i`=1) of the active bank as its address, for both reads and writes.
- R6: When the indirect pointer is above 7FH, `ind_oor_o` is 1, `ind_rd_data_o` is 00H and an indirect write changes no byte.
- R7: A push first increments the stack pointer and then writes `push_data_i` at the new stack pointer. `pop_data_o` always shows the byte at the current stack pointer. A pop decrements the stack pointer after that byte has been read.
- R8: When a push targets an address above 7FH, or a pop is made while the stack pointer is above 7FH, `stk_oor_o` is 1. The stack pointer still moves. A push in this case writes nothing, and `pop_data_o` reads 00H whenever the stack pointer is above 7FH.
- R9: A push and a pop in the same cycle perform the push only. The pop is ignored.
- R10: When several writes fall in one cycle, only one byte is written. The winner is chosen in this order: push, then indirect, then direct, then register, then bit set/clear.
- R11: A read of a byte that is being written in the same cycle returns the old value. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | 2 | Active register bank |
| reg_rd_idx_i | input | 3 | Register number to read |
| reg_rd_data_o | output | 8 | Register read data |
| reg_we_i | input | 1 | Register write strobe |
| reg_wr_idx_i | input | 3 | Register number to write |
| reg_wr_data_i | input | 8 | Register write data |
| dir_rd_addr_i | input | 7 | Direct read address |
| dir_rd_data_o | output | 8 | Direct read data |
| dir_we_i | input | 1 | Direct write strobe |
| dir_wr_addr_i | input | 7 | Direct write address |
| dir_wr_data_i | input | 8 | Direct write data |
| ind_sel_i | input | 1 | Pointer choice: 0 selects register 0, 1 selects register 1 |
| ind_we_i | input | 1 | Indirect write strobe |
| ind_wr_data_i | input | 8 | Indirect write data |
| ind_rd_data_o | output | 8 | Indirect read data |
| ind_oor_o | output | 1 | Indirect pointer above 7FH |
| bit_addr_i | input | 7 | Bit address |
| bit_set_i | input | 1 | Set the addressed bit |
| bit_clr_i | input | 1 | Clear the addressed bit |
| bit_rd_o | output | 1 | Value of the addressed bit |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | 8 | Byte at the stack pointer |
| sp_o | output | 8 | Stack pointer |
| stk_oor_o | output | 1 | Stack access above 7FH |

## Verification
On every cycle, the assertions check that the register port and the bit port agree with the direct port whenever they point at the same byte. They also check the stack pointer step for push, pop, both strobes together and idle, that out-of-range reads return zero, and that a lone direct write shows up one cycle later. Some behaviour can only be shown by the bench's scenarios: which of several same-cycle writers wins, that a suppressed out-of-range write does not alias into the low bytes, the reset image, and filling the stack up to its top and past it.

// File: rtl/iram_pkg.sv
package iram_pkg;
  localparam int DATA_W    = 8;
  localparam int DEPTH     = 128;
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int PTR_W     = 8;
  localparam int N_BANKS   = 4;
  localparam int BANK_W    = $clog2(N_BANKS);
  localparam int REGS      = 8;
  localparam int REG_W     = $clog2(REGS);
  localparam int BIT_BYTES = 16;
  localparam logic [ADDR_W-1:0] BIT_BASE = 7'h20;
  localparam logic [PTR_W-1:0]  SP_RESET = 8'h07;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;

  // write sources, highest priority first
  typedef enum int {SRC_PUSH = 0, SRC_IND = 1, SRC_DIR = 2, SRC_REG = 3, SRC_BIT = 4, N_SRC = 5} wr_src_e;
endpackage

// File: rtl/iram_store.sv
module iram_store
  import iram_pkg::*;
#(
  parameter int N_RD = 6
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  wr_req_t                        wr_i,
  input  logic [N_RD-1:0][ADDR_W-1:0]    rd_addr_i,
  output logic [N_RD-1:0][DATA_W-1:0]    rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i.en) begin
      mem_q[wr_i.addr] <= wr_i.data;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_addr_i[g]];
  end
endmodule

// File: rtl/iram_wr_arb.sv
module iram_wr_arb
  import iram_pkg::*;
#(
  parameter int N_REQ = N_SRC
) (
  input  wr_req_t [N_REQ-1:0] req_i,
  output wr_req_t             wr_o
);
  // index 0 wins
  always_comb begin
    wr_o = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req_i[i].en) wr_o = req_i[i];
    end
  end
endmodule

// File: rtl/iram_stack_ctl.sv
module iram_stack_ctl
  import iram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic [PTR_W-1:0]  push_ptr_o,
  output logic              push_oor_o,
  output logic              top_oor_o,
  output logic              pop_oor_o
);
  logic [PTR_W-1:0] sp_q, sp_d;
  logic             pop_en;

  assign push_ptr_o = sp_q + PTR_W'(1);
  assign pop_en     = pop_i & ~push_i;
  assign push_oor_o = push_i & (push_ptr_o >= PTR_W'(DEPTH));
  assign top_oor_o  = sp_q >= PTR_W'(DEPTH);
  assign pop_oor_o  = pop_en & top_oor_o;

  always_comb begin
    sp_d = sp_q;
    if (push_i)      sp_d = push_ptr_o;
    else if (pop_en) sp_d = sp_q - PTR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= SP_RESET;
    else         sp_q <= sp_d;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/iram_bank_file.sv
module iram_bank_file
  import iram_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bank_sel_i,
  input  logic [2:0]        reg_rd_idx_i,
  output logic [7:0]        reg_rd_data_o,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_wr_idx_i,
  input  logic [7:0]        reg_wr_data_i,
  input  logic [6:0]        dir_rd_addr_i,
  output logic [7:0]        dir_rd_data_o,
  input  logic              dir_we_i,
  input  logic [6:0]        dir_wr_addr_i,
  input  logic [7:0]        dir_wr_data_i,
  input  logic              ind_sel_i,
  input  logic              ind_we_i,
  input  logic [7:0]        ind_wr_data_i,
  output logic [7:0]        ind_rd_data_o,
  output logic              ind_oor_o,
  input  logic [6:0]        bit_addr_i,
  input  logic              bit_set_i,
  input  logic              bit_clr_i,
  output logic              bit_rd_o,
  input  logic              push_i,
  input  logic [7:0]        push_data_i,
  input  logic              pop_i,
  output logic [7:0]        pop_data_o,
  output logic [7:0]        sp_o,
  output logic              stk_oor_o
);
  localparam int RP_REG = 0;
  localparam int RP_DIR = 1;
  localparam int RP_PTR = 2;
  localparam int RP_IND = 3;
  localparam int RP_BIT = 4;
  localparam int RP_POP = 5;
  localparam int N_RP   = 6;
  localparam int BIT_IDX_W = $clog2(DATA_W);

  logic [N_RP-1:0][ADDR_W-1:0] rd_addr;
  logic [N_RP-1:0][DATA_W-1:0] rd_data;
  wr_req_t [N_SRC-1:0]         reqs;
  wr_req_t                     wr;

  logic [PTR_W-1:0]     ptr, push_ptr;
  logic                 push_oor, top_oor, pop_oor;
  logic [ADDR_W-1:0]    bit_byte;
  logic [DATA_W-1:0]    bit_mask, bit_new;

  function automatic logic [ADDR_W-1:0] bank_addr(logic [BANK_W-1:0] b, logic [REG_W-1:0] r);
    return ADDR_W'({b, r});
  endfunction

  iram_stack_ctl u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .sp_o       (sp_o),
    .push_ptr_o (push_ptr),
    .push_oor_o (push_oor),
    .top_oor_o  (top_oor),
    .pop_oor_o  (pop_oor)
  );

  // address generation
  assign bit_byte = BIT_BASE + ADDR_W'(bit_addr_i[ADDR_W-1:BIT_IDX_W]);
  assign rd_addr[RP_REG] = bank_addr(bank_sel_i, reg_rd_idx_i);
  assign rd_addr[RP_DIR] = dir_rd_addr_i;
  assign rd_addr[RP_PTR] = bank_addr(bank_sel_i, {2'b00, ind_sel_i});
  assign ptr             = rd_data[RP_PTR];
  assign rd_addr[RP_IND] = ptr[ADDR_W-1:0];
  assign rd_addr[RP_BIT] = bit_byte;
  assign rd_addr[RP_POP] = sp_o[ADDR_W-1:0];

  iram_store #(.N_RD(N_RP)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  // read side
  assign ind_oor_o     = ptr[PTR_W-1];
  assign reg_rd_data_o = rd_data[RP_REG];
  assign dir_rd_data_o = rd_data[RP_DIR];
  assign ind_rd_data_o = ind_oor_o ? '0 : rd_data[RP_IND];
  assign bit_rd_o      = rd_data[RP_BIT][bit_addr_i[BIT_IDX_W-1:0]];
  assign pop_data_o    = top_oor ? '0 : rd_data[RP_POP];
  assign stk_oor_o     = push_oor | pop_oor;

  // bit read-modify-write, set beats clear
  assign bit_mask = DATA_W'(1) << bit_addr_i[BIT_IDX_W-1:0];
  assign bit_new  = bit_set_i ? (rd_data[RP_BIT] | bit_mask) : (rd_data[RP_BIT] & ~bit_mask);

  // write requests
  assign reqs[SRC_PUSH] = '{en: push_i & ~push_oor, addr: push_ptr[ADDR_W-1:0], data: push_data_i};
  assign reqs[SRC_IND]  = '{en: ind_we_i & ~ind_oor_o, addr: ptr[ADDR_W-1:0], data: ind_wr_data_i};
  assign reqs[SRC_DIR]  = '{en: dir_we_i, addr: dir_wr_addr_i, data: dir_wr_data_i};
  assign reqs[SRC_REG]  = '{en: reg_we_i, addr: bank_addr(bank_sel_i, reg_wr_idx_i), data: reg_wr_data_i};
  assign reqs[SRC_BIT]  = '{en: bit_set_i | bit_clr_i, addr: bit_byte, data: bit_new};

  iram_wr_arb #(.N_REQ(N_SRC)) u_arb (
    .req_i (reqs),
    .wr_o  (wr)
  );
endmodule

// File: rtl/iram_bank_file_chk.sv
module iram_bank_file_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] bank_sel_i,
  input logic [2:0] reg_rd_idx_i,
  input logic [7:0] reg_rd_data_o,
  input logic       dir_we_i,
  input logic [6:0] dir_wr_addr_i,
  input logic [7:0] dir_wr_data_i,
  input logic [6:0] dir_rd_addr_i,
  input logic [7:0] dir_rd_data_o,
  input logic       ind_we_i,
  input logic       ind_oor_o,
  input logic [7:0] ind_rd_data_o,
  input logic [6:0] bit_addr_i,
  input logic       bit_rd_o,
  input logic       push_i,
  input logic       pop_i,
  input logic [7:0] pop_data_o,
  input logic [7:0] sp_o,
  input logic       stk_oor_o
);
  // R2
  reg_dir_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rd_addr_i == {2'b00, bank_sel_i, reg_rd_idx_i}) |-> (reg_rd_data_o == dir_rd_data_o));

  // R4
  bit_byte_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rd_addr_i == 7'h20 + {3'b000, bit_addr_i[6:3]}) |-> (bit_rd_o == dir_rd_data_o[bit_addr_i[2:0]]));

  // R6
  ind_oor_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ind_oor_o |-> (ind_rd_data_o == 8'h00));

  // R7
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (sp_o == $past(sp_o) + 8'd1));

  // R7
  pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (sp_o == $past(sp_o) - 8'd1));

  // R9
  sp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(sp_o));

  // R8
  stk_oor_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_oor_o && !push_i) |-> (pop_data_o == 8'h00));

  // R11
  dir_wr_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_we_i && !push_i && !ind_we_i) |=>
      ((dir_rd_addr_i != $past(dir_wr_addr_i)) || (dir_rd_data_o == $past(dir_wr_data_i))));
endmodule

bind iram_bank_file iram_bank_file_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bank_sel_i    (bank_sel_i),
  .reg_rd_idx_i  (reg_rd_idx_i),
  .reg_rd_data_o (reg_rd_data_o),
  .dir_we_i      (dir_we_i),
  .dir_wr_addr_i (dir_wr_addr_i),
  .dir_wr_data_i (dir_wr_data_i),
  .dir_rd_addr_i (dir_rd_addr_i),
  .dir_rd_data_o (dir_rd_data_o),
  .ind_we_i      (ind_we_i),
  .ind_oor_o     (ind_oor_o),
  .ind_rd_data_o (ind_rd_data_o),
  .bit_addr_i    (bit_addr_i),
  .bit_rd_o      (bit_rd_o),
  .push_i        (push_i),
  .pop_i         (pop_i),
  .pop_data_o    (pop_data_o),
  .sp_o          (sp_o),
  .stk_oor_o     (stk_oor_o)
);

// File: tb/iram_bank_file_tb.sv
module iram_bank_file_tb_top;
  localparam int CLK_P = 10;
  localparam int N_VEC = 8;
  // {bank, reg number, expected byte address, data}
  localparam logic [31:0] VEC [N_VEC] = '{
    32'h00_00_00_3C, 32'h00_07_07_C1, 32'h01_00_08_5A, 32'h01_05_0D_E7,
    32'h02_03_13_99, 32'h02_06_16_2B, 32'h03_01_19_7E, 32'h03_07_1F_F0
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] bank_sel_i = '0;
  logic [2:0] reg_rd_idx_i = '0, reg_wr_idx_i = '0;
  logic [7:0] reg_rd_data_o, reg_wr_data_i = '0;
  logic reg_we_i = 0, dir_we_i = 0, ind_sel_i = 0, ind_we_i = 0;
  logic [6:0] dir_rd_addr_i = '0, dir_wr_addr_i = '0, bit_addr_i = '0;
  logic [7:0] dir_rd_data_o, dir_wr_data_i = '0, ind_wr_data_i = '0, ind_rd_data_o;
  logic ind_oor_o, bit_set_i = 0, bit_clr_i = 0, bit_rd_o, push_i = 0, pop_i = 0, stk_oor_o;
  logic [7:0] push_data_i = '0, pop_data_o, sp_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  iram_bank_file dut_i (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 0; dir_we_i = 0; ind_we_i = 0; bit_set_i = 0; bit_clr_i = 0;
    push_i = 0; pop_i = 0;
  endtask

  task automatic rd_dir(string req, logic [6:0] a, logic [7:0] exp);
    dir_rd_addr_i = a; #1; chk(req, dir_rd_data_o, exp);
  endtask

  task automatic wr_reg(logic [1:0] b, logic [2:0] i, logic [7:0] d);
    bank_sel_i = b; reg_wr_idx_i = i; reg_wr_data_i = d; reg_we_i = 1; step();
  endtask

  task automatic do_reset();
    rst_ni = 0; #(CLK_P*2); @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
  endtask

  initial begin
    #(CLK_P*100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset image
    chk("R1 sp", sp_o, 8'h07);
    rd_dir("R1 mem00", 7'h00, 8'h00);
    rd_dir("R1 mem2F", 7'h2F, 8'h00);
    rd_dir("R1 mem7F", 7'h7F, 8'h00);

    // R2 bank mapping table
    for (int v = 0; v < N_VEC; v++) begin
      wr_reg(VEC[v][25:24], VEC[v][18:16], VEC[v][7:0]);
      rd_dir("R2 direct view", VEC[v][14:8], VEC[v][7:0]);
      reg_rd_idx_i = VEC[v][18:16]; #1;
      chk("R2 reg view", reg_rd_data_o, VEC[v][7:0]);
    end

    // R3 low direct addresses are bank 0
    bank_sel_i = 2'd3; dir_wr_addr_i = 7'h04; dir_wr_data_i = 8'hA4; dir_we_i = 1; step();
    reg_rd_idx_i = 3'd4; #1; chk("R3 bank3 r4 untouched", reg_rd_data_o, 8'h00);
    bank_sel_i = 2'd0; #1; chk("R3 bank0 r4", reg_rd_data_o, 8'hA4);
    rd_dir("R3 top byte", 7'h7F, 8'h00);

    // R11 same-cycle read returns old value
    dir_wr_addr_i = 7'h50; dir_wr_data_i = 8'h5A; dir_we_i = 1; rd_dir("R11 old", 7'h50, 8'h00);
    step(); rd_dir("R11 new", 7'h50, 8'h5A);

    // R5 indirect via R0/R1 of bank 1
    wr_reg(2'd1, 3'd0, 8'h45);
    wr_reg(2'd1, 3'd1, 8'h85);
    ind_sel_i = 0; ind_wr_data_i = 8'h77; ind_we_i = 1; step();
    rd_dir("R5 ind write", 7'h45, 8'h77);
    #1; chk("R5 ind read", ind_rd_data_o, 8'h77);
    chk("R5 in range", {7'd0, ind_oor_o}, 8'h00);
    // R6 pointer 85H out of range
    ind_sel_i = 1; #1;
    chk("R6 flag", {7'd0, ind_oor_o}, 8'h01);
    chk("R6 read zero", ind_rd_data_o, 8'h00);
    ind_wr_data_i = 8'hEE; ind_we_i = 1; step();
    rd_dir("R6 no alias", 7'h05, 8'h00);

    // R10 direct beats register, indirect beats direct
    bank_sel_i = 0; reg_wr_idx_i = 3'd3; reg_wr_data_i = 8'h33; reg_we_i = 1;
    dir_wr_addr_i = 7'h03; dir_wr_data_i = 8'hDD; dir_we_i = 1; step();
    rd_dir("R10 dir over reg", 7'h03, 8'hDD);
    ind_sel_i = 0; ind_wr_data_i = 8'h66; ind_we_i = 1;
    dir_wr_addr_i = 7'h3C; dir_wr_data_i = 8'h99; dir_we_i = 1; step();
    rd_dir("R10 ind over dir", 7'h3C, 8'h66);

    // R4 bit port
    bit_addr_i = 7'h0B; bit_set_i = 1; step();
    rd_dir("R4 set 0B", 7'h21, 8'h08);
    #1; chk("R4 bit read", {7'd0, bit_rd_o}, 8'h01);
    bit_addr_i = 7'h7F; bit_set_i = 1; step();
    rd_dir("R4 set 7F", 7'h2F, 8'h80);
    bit_addr_i = 7'h0B; bit_clr_i = 1; step();
    rd_dir("R4 clr 0B", 7'h21, 8'h00);
    bit_addr_i = 7'h00; bit_set_i = 1; bit_clr_i = 1; step();
    rd_dir("R4 set wins", 7'h20, 8'h01);

    // stack
    do_reset();
    push_data_i = 8'h11; push_i = 1; step();
    chk("R7 sp push", sp_o, 8'h08);
    rd_dir("R7 push data", 7'h08, 8'h11);
    push_data_i = 8'h22; push_i = 1; step();
    #1; chk("R7 top", pop_data_o, 8'h22);
    pop_i = 1; step();
    chk("R7 sp pop", sp_o, 8'h08);
    chk("R7 new top", pop_data_o, 8'h11);
    push_data_i = 8'h33; push_i = 1; pop_i = 1; step();
    chk("R9 sp", sp_o, 8'h09);
    rd_dir("R9 data", 7'h09, 8'h33);
    for (int k = 0; k < 118; k++) begin
      push_data_i = 8'hAA; push_i = 1; step();
    end
    chk("R8 full sp", sp_o, 8'h7F);
    push_data_i = 8'hBB; push_i = 1; #1;
    chk("R8 push flag", {7'd0, stk_oor_o}, 8'h01);
    step();
    chk("R8 sp moved", sp_o, 8'h80);
    rd_dir("R8 no alias", 7'h00, 8'h00);
    chk("R8 read zero", pop_data_o, 8'h00);
    pop_i = 1; #1;
    chk("R8 pop flag", {7'd0, stk_oor_o}, 8'h01);
    step();
    chk("R8 sp back", sp_o, 8'h7F);
    chk("R8 top", pop_data_o, 8'hAA);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule